// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Page-Write Engine

This block models the write side of a byte-wide nonvolatile memory that the host accesses like a static RAM. Host write strobes do not reach the storage array directly. Each accepted strobe captures an address and a data byte into an internal page buffer. The first byte of a burst fixes which page the burst targets. Bytes can keep arriving as long as each one lands within a load window that counts from the previous byte.

When the window runs out, a self-timed commit cycle starts without any further action from the host. The cycle copies the loaded bytes of the page into the array and lasts a fixed number of clocks. While it runs, the host bus is free, but reads return a polling word instead of array data. The host polls the most significant data bit until it matches the last byte it wrote. After that, normal reads and writes may resume.

The array has 8192 bytes behind a 13-bit address. The page holds 64 bytes. The load window and the commit length are parameters, given in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: Address bits 12:6 name the page and bits 5:0 name the byte inside it. All bytes of one burst go to the page of the first byte in that burst, whatever page bits the later bytes carry.
- R2: A byte is captured only on the clock where the combined strobe (chip enable low and write enable low) becomes active after being inactive. Holding the strobe active for several clocks captures one byte, with the data present at that first clock. Write enable low while chip enable is high captures nothing.
- R3: Every captured byte restarts a window of LOAD_WINDOW clocks. When the window expires with no new byte, the commit cycle starts. A strobe on the exact clock of expiry is still absorbed into the current burst.
- R4: A commit updates only the page offsets loaded in that burst, and every other byte of the page keeps its old value. If an offset is loaded twice, the later byte is stored.
- R5: While the commit cycle runs, a read returns the inverse of bit 7 of the last loaded byte on bit 7, with bits 6:0 at zero.
- R6: Write strobes that arrive while the commit cycle runs are ignored and change no stored byte.
- R7: The commit cycle ends WRITE_CYCLES clocks after it starts. From then on, reads return the stored array contents for bursts of any size from 1 to 64 bytes.
- R8: A read is requested when chip enable and output enable are low and write enable is high. The data output and its valid flag are registered one clock after the request. Without a request, both are zero.
- R9: During synchronous reset the data output and its valid flag are zero, and no commit cycle is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 13 | Byte address (page in 12:6, offset in 5:0) |
| din | input | 8 | Write data from host |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dout | output | 8 | Read data or polling word |
| dout_en | output | 1 | High when dout carries a read result |

## Verification
Two functions can fall on the same clock: the load window expiring and a new write strobe arriving. The bench provokes this by spacing a second byte exactly LOAD_WINDOW-1 idle clocks after the first, and it gives that second byte a different page field. If the byte is correctly absorbed, it appears in the first byte's page after the commit. A neighbouring case spaces the strobe one clock later, so that it arrives after the commit has started. The bench then checks that this byte is dropped and the targeted location keeps its old value.

// File: rtl/eepw_pkg.sv
// Shared types for the page-write engine.
package eepw_pkg;

    // Load-side state: idle (no burst open) or filling the page buffer.
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } load_state_e;

endpackage

// File: rtl/eepw_strobe.sv
// Write-strobe edge detector.
// Produces a one-clock pulse on the clock where the combined active-low
// strobe (ce_n OR we_n) goes from inactive to active.
// Assumes ce_n / we_n are already synchronous to clk.
module eepw_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic wr_pulse
);

    logic strobe_n;
    logic strobe_n_q;

    assign strobe_n = ce_n | we_n;

    // Remember last strobe level; reset as inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_n_q <= 1'b1;
        end else begin
            strobe_n_q <= strobe_n;
        end
    end

    assign wr_pulse = strobe_n_q & ~strobe_n;

endmodule

// File: rtl/eepw_page_latch.sv
// Page buffer and load-window timer.
// Captures bytes into a page-wide buffer with a per-byte loaded mask.
// The first byte of a burst fixes the page. Each byte restarts the window;
// expiry raises commit_start for one clock.
// Assumes the commit engine holds busy high from the clock after
// commit_start until the commit is over, and that buffer contents are
// only read while busy.
module eepw_page_latch
    import eepw_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 6,
    parameter int DATA_W      = 8,
    parameter int LOAD_WINDOW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_pulse,
    input  logic                     busy,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        din,
    input  logic [PAGE_W-1:0]        rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_mask,
    output logic [ADDR_W-PAGE_W-1:0] page_q,
    output logic                     last_msb,
    output logic                     wr_accept,
    output logic                     commit_start
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int WIN_W      = $clog2(LOAD_WINDOW + 1);

    load_state_e             state_q;
    logic [WIN_W-1:0]        win_q;
    logic [PAGE_BYTES-1:0]   mask_q;
    logic [PAGE_BYTES-1:0]   hit;
    logic [DATA_W-1:0]       buf_q [PAGE_BYTES];

    assign wr_accept    = wr_pulse & ~busy;
    assign hit          = {{(PAGE_BYTES-1){1'b0}}, 1'b1} << addr[PAGE_W-1:0];
    assign commit_start = (state_q == LD_FILL) && !wr_accept &&
                          (win_q == WIN_W'(LOAD_WINDOW - 1));

    // Burst state, window counter, page number, mask and last-byte MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LD_IDLE;
            win_q    <= '0;
            mask_q   <= '0;
            page_q   <= '0;
            last_msb <= 1'b0;
        end else if (wr_accept) begin
            win_q    <= '0;
            last_msb <= din[DATA_W-1];
            state_q  <= LD_FILL;
            if (state_q == LD_IDLE) begin
                page_q <= addr[ADDR_W-1:PAGE_W];
                mask_q <= hit;
            end else begin
                mask_q <= mask_q | hit;
            end
        end else if (commit_start) begin
            state_q <= LD_IDLE;
            win_q   <= '0;
        end else if (state_q == LD_FILL) begin
            win_q <= win_q + WIN_W'(1);
        end
    end

    // One data register per page offset; written when its offset is hit.
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_buf
        always_ff @(posedge clk) begin
            if (wr_accept && hit[i]) begin
                buf_q[i] <= din;
            end
        end
    end

    assign rd_data = buf_q[rd_idx];
    assign rd_mask = mask_q[rd_idx];

endmodule

// File: rtl/eepw_commit.sv
// Self-timed commit sequencer.
// On start, runs for WRITE_CYCLES clocks. During the first PAGE_BYTES of
// them it walks the page offsets and issues one array write per loaded byte.
// Assumes WRITE_CYCLES >= 2**PAGE_W so that the walk fits in the cycle.
module eepw_commit #(
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mask_bit,
    output logic              busy,
    output logic [PAGE_W-1:0] idx,
    output logic              mem_we
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CYC_W      = $clog2(WRITE_CYCLES + 1);

    logic [CYC_W-1:0] cnt_q;
    logic             in_page;

    assign idx     = cnt_q[PAGE_W-1:0];
    assign in_page = cnt_q < CYC_W'(PAGE_BYTES);
    assign mem_we  = busy & in_page & mask_bit;

    // Busy flag and cycle counter for the timed commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == CYC_W'(WRITE_CYCLES - 1)) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CYC_W'(1);
            end
        end
    end

endmodule

// File: rtl/eeprom_page_writer.sv
// Top of the page-write engine.
// Holds the storage array and the registered read path. Reads return
// array data when idle, and the polling word while a commit runs.
// Assumes all host inputs are synchronous to clk.
module eeprom_page_writer #(
    parameter int ADDR_W       = 13,
    parameter int PAGE_W       = 6,
    parameter int DATA_W       = 8,
    parameter int LOAD_WINDOW  = 18750,
    parameter int WRITE_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SEL_W = ADDR_W - PAGE_W;

    logic              wr_pulse;
    logic              wr_accept;
    logic              commit_start;
    logic              busy;
    logic              mask_bit;
    logic              mem_we;
    logic              last_msb;
    logic              rd_req;
    logic [PAGE_W-1:0] idx;
    logic [SEL_W-1:0]  page_q;
    logic [DATA_W-1:0] page_byte;
    logic [DATA_W-1:0] mem [DEPTH];

    eepw_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .wr_pulse (wr_pulse)
    );

    eepw_page_latch #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .DATA_W      (DATA_W),
        .LOAD_WINDOW (LOAD_WINDOW)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_pulse     (wr_pulse),
        .busy         (busy),
        .addr         (addr),
        .din          (din),
        .rd_idx       (idx),
        .rd_data      (page_byte),
        .rd_mask      (mask_bit),
        .page_q       (page_q),
        .last_msb     (last_msb),
        .wr_accept    (wr_accept),
        .commit_start (commit_start)
    );

    eepw_commit #(
        .PAGE_W       (PAGE_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (commit_start),
        .mask_bit (mask_bit),
        .busy     (busy),
        .idx      (idx),
        .mem_we   (mem_we)
    );

    // Array write port, driven only by the commit sequencer.
    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[{page_q, idx}] <= page_byte;
        end
    end

    assign rd_req = ~ce_n & ~oe_n & we_n;

    // Registered read path: polling word while busy, array data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_req;
            if (!rd_req) begin
                dout <= '0;
            end else if (busy) begin
                dout <= {~last_msb, {(DATA_W-1){1'b0}}};
            end else begin
                dout <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/eepw_checker.sv
// Temporal checks on the page-write engine, bound into every instance.
module eepw_checker #(
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              busy,
    input logic              wr_accept,
    input logic              commit_start,
    input logic              mem_we
);

    logic rd;
    int   busy_run;

    assign rd = ~ce_n & ~oe_n & we_n;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_accept); // R6
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_start |=> busy); // R3
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_start |-> !busy); // R3
    AST_POLL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy) |=> (dout_en && dout[DATA_W-2:0] == '0)); // R5
    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (dout == '0 && !dout_en)); // R8
    AST_ARRAY_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R4
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < WRITE_CYCLES); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !dout_en)); // R9

endmodule

bind eeprom_page_writer eepw_checker #(
    .DATA_W       (DATA_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .dout         (dout),
    .dout_en      (dout_en),
    .busy         (busy),
    .wr_accept    (wr_accept),
    .commit_start (commit_start),
    .mem_we       (mem_we)
);

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;

    localparam int LW = 16;
    localparam int WC = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [7:0]  dout;
    logic        dout_en;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0]  mdl [8192];
    logic [6:0]  pend_page;
    logic [7:0]  pend_data [64];
    logic [63:0] pend_mask;
    int          pend_n = 0;
    logic [7:0]  pend_last;
    logic [12:0] pend_last_a;

    eeprom_page_writer #(
        .LOAD_WINDOW  (LW),
        .WRITE_CYCLES (WC)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .dout    (dout),
        .dout_en (dout_en)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] poll_word(input logic [7:0] last);
        return {~last[7], 7'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd_byte(input logic [12:0] a, output logic [7:0] v, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Model side of one loaded byte: page fixed by the first byte.
    task automatic note_byte(input logic [12:0] a, input logic [7:0] d);
        if (pend_n == 0) begin
            pend_page = a[12:6];
            pend_mask = '0;
        end
        pend_data[a[5:0]] = d;
        pend_mask[a[5:0]] = 1'b1;
        pend_n++;
        pend_last   = d;
        pend_last_a = {pend_page, a[5:0]};
    endtask

    task automatic ld(input logic [12:0] a, input logic [7:0] d);
        wr_byte(a, d);
        note_byte(a, d);
    endtask

    // Let the window expire, try an ignored write, check polling, wait for completion.
    task automatic finish_load();
        logic [7:0]  v;
        logic        en;
        logic [12:0] ign_a;
        bit          seen;
        for (int i = 0; i < 64; i++) begin
            if (pend_mask[i]) mdl[{pend_page, 6'(i)}] = pend_data[i];
        end
        pend_n = 0;
        ign_a = {pend_page, 6'($urandom % 64)};
        repeat (LW - 1) @(negedge clk);
        wr_byte(ign_a, ~mdl[ign_a]);                  // R6 arrives one clock after commit start
        rd_byte(pend_last_a, v, en);
        check("R5 polling word", v, poll_word(pend_last));
        seen = 1'b0;
        for (int k = 0; k < 300 && !seen; k++) begin
            rd_byte(pend_last_a, v, en);
            if (v[7] == pend_last[7]) seen = 1'b1;
        end
        check("R7 completion data", v, mdl[pend_last_a]);
        rd_byte(ign_a, v, en);
        check("R6 ignored strobe", v, mdl[ign_a]);
    endtask

    task automatic check_page(input logic [6:0] pg, input string tag);
        logic [7:0] v;
        logic       en;
        for (int i = 0; i < 64; i++) begin
            rd_byte({pg, 6'(i)}, v, en);
            check(tag, v, mdl[{pg, 6'(i)}]);
        end
    endtask

    task automatic fill_page(input logic [6:0] pg);
        for (int i = 0; i < 64; i++) ld({pg, 6'(i)}, 8'($urandom));
        finish_load();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       en;
        void'($urandom(32'd2718));

        // R9 reset state
        repeat (4) @(negedge clk);
        check("R9 dout in reset", dout, 8'h00);
        check("R9 dout_en in reset", {7'b0, dout_en}, 8'h00);
        rst_n = 1'b1;

        // Full page, then R7 full-size readback
        fill_page(7'd5);
        check_page(7'd5, "R7 full page readback");

        // R8 read latency and idle bus
        rd_byte(13'({7'd5, 6'd9}), v, en);
        check("R8 read valid flag", {7'b0, en}, 8'h01);
        @(negedge clk);
        check("R8 idle dout", dout, 8'h00);

        // R1 / R4: partial burst, foreign page bits, repeated offset
        ld({7'd5, 6'd3}, 8'hA5);
        ld({7'd9, 6'd20}, 8'h3C);                    // R1 lands in page 5
        ld({7'd5, 6'd10}, 8'h11);
        rd_byte({7'd5, 6'd3}, v, en);
        check("R3 read during load sees old data", v, mdl[{7'd5, 6'd3}]);
        ld({7'd5, 6'd10}, 8'h99);                    // R4 later byte wins
        ld({7'd5, 6'd63}, 8'h80);
        finish_load();
        check_page(7'd5, "R1/R4 partial page");

        // R2 held strobe captures first data; we_n alone captures nothing
        @(negedge clk);
        addr = {7'd5, 6'd40}; din = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); din = 8'hC3;
        @(negedge clk); din = 8'h0F;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        note_byte({7'd5, 6'd40}, 8'h5A);
        @(negedge clk); addr = {7'd5, 6'd41}; din = 8'hEE; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        finish_load();
        rd_byte({7'd5, 6'd40}, v, en);
        check("R2 held strobe first data", v, 8'h5A);
        rd_byte({7'd5, 6'd41}, v, en);
        check("R2 we_n without ce_n", v, mdl[{7'd5, 6'd41}]);

        // R3 strobe on the expiry clock is absorbed (page 2 bits ignored)
        fill_page(7'd7);
        ld({7'd7, 6'd1}, 8'h42);
        repeat (LW - 2) @(negedge clk);
        ld({7'd2, 6'd4}, 8'hB7);
        finish_load();
        rd_byte({7'd7, 6'd4}, v, en);
        check("R3 race byte absorbed", v, 8'hB7);
        check_page(7'd7, "R3 race page");

        // Random bursts over pre-filled pages
        for (int r = 0; r < 8; r++) begin
            logic [6:0] pg;
            int n;
            pg = 7'($urandom % 128);
            fill_page(pg);
            n = 1 + int'($urandom % 64);
            for (int j = 0; j < n; j++) ld({pg, 6'($urandom % 64)}, 8'($urandom));
            finish_load();
            check_page(pg, "R4/R7 random burst");
        end

        // Single-byte burst
        ld({7'd5, 6'd0}, 8'h7E);
        finish_load();
        check_page(7'd5, "R7 single byte");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule